// File: doc/BRIEF.md
# Receive Message Queue Index Manager

This block keeps the bookkeeping for one circular receive queue whose elements live in a shared message memory. The queue depth can be set anywhere from 1 to 64 elements. When an accepted message arrives, the block either grants it a slot and supplies the word address to write, or discards the message because the queue is full. The write index moves forward only after the store has finished. The host reads an element from a word address that the block derives from the read index. To acknowledge the read, the host hands back the new read index.

Three flags report the queue state. The full flag is a plain level. The watermark flag and the lost-message flag are sticky, and the host clears each one by pulsing a clear input. A programmable watermark warns the host before the queue overflows. The block does not include the memory itself, the acceptance filtering or the bus protocol.

Top module: `rxq_index_mgr`

## Requirements
- R1: When `store_req` is high, no store is pending and the queue is not full, `store_grant` is high in the same cycle. While the store is pending, `wr_addr` equals `cfg_start_addr + 4*put_idx`.
- R2: `put_idx` changes only on the clock edge where `store_done` is high while a store is pending. It then advances by one, and after `cfg_size-1` it goes back to 0.
- R3: `flag_full` is high exactly when `fill_level` equals `cfg_size`. A `store_req` that arrives while the queue is full and no store is pending raises `store_drop` in that cycle, and no index changes.
- R4: Each drop sets the sticky `flag_lost` on the next edge.
- R5: `flag_wmark` is set on the edge where a store completes and the resulting fill level equals a nonzero `cfg_wmark`. A `cfg_wmark` of 0 never sets the flag.
- R6: When `ack_valid` is high and `ack_get_idx` differs from `get_idx`, `get_idx` loads `ack_get_idx`. If the new index is numerically smaller than the old one, the read side has wrapped. `fill_level` is derived from both indices and their wrap state.
- R7: `rd_addr` always equals `cfg_start_addr + 4*get_idx`.
- R8: A high `clr_wmark` clears `flag_wmark` on the next edge, and a high `clr_lost` does the same for `flag_lost`. When a set event and a clear fall in the same cycle, the flag ends up set.
- R9: While reset is active, and after it is released, both indices and the fill level are 0 and every flag is low.
- R10: While a store is pending, `store_req` produces neither a grant nor a drop. A `store_done` that arrives with no store pending has no effect.
- R11: Depths of 1 and 64 both work: the fill level reaches the configured depth, and both indices wrap at that depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_start_addr | input | ADDR_W | Word address of queue element 0 |
| cfg_size | input | IDX_W+1 | Queue depth, 1 to 64 |
| cfg_wmark | input | IDX_W+1 | Watermark fill level, 0 disables it |
| store_req | input | 1 | An accepted message wants a slot |
| store_done | input | 1 | The granted store has been written |
| store_grant | output | 1 | Slot granted this cycle |
| store_drop | output | 1 | Message discarded this cycle because the queue is full |
| wr_addr | output | ADDR_W | Word address for the store |
| ack_valid | input | 1 | Host acknowledges reads |
| ack_get_idx | input | IDX_W | New read index from the host |
| put_idx | output | IDX_W | Write index |
| get_idx | output | IDX_W | Read index |
| fill_level | output | IDX_W+1 | Elements held in the queue |
| rd_addr | output | ADDR_W | Word address of the oldest element |
| flag_full | output | 1 | Queue full |
| flag_wmark | output | 1 | Sticky watermark reached |
| flag_lost | output | 1 | Sticky message lost |
| clr_wmark | input | 1 | Clear `flag_wmark` |
| clr_lost | input | 1 | Clear `flag_lost` |

## Verification
The bench fills a 4-deep queue until it is full and then offers one more message. A design that overwrote the oldest element would return a grant and move the write index, when it should drop the message. It also moves the read index backwards across the boundary. A design that ignored the wrap state would then report a fill level of 4, or a negative one, for an empty queue. Set and clear are applied together on both sticky flags, so a design that gives priority to the clear loses that event. The bench also runs the queue at depth 1 and at depth 64 with the watermark at 0. This exposes wrap limits that are off by one, a write address that lags the write index, and a watermark that fires even though it is disabled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } store_st_e;
endpackage

// File: rtl/rxq_put_ctr.sv
module rxq_put_ctr #(
  parameter int IDX_W = 6,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cfg_size,
  output logic [IDX_W-1:0] idx,
  output logic             wrap,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             wrap_nxt
);
  logic at_end;

  always_comb begin
    at_end   = ({1'b0, idx} == (cfg_size - CNT_W'(1)));
    idx_nxt  = idx;
    wrap_nxt = wrap;
    if (adv) begin
      if (at_end) begin
        idx_nxt  = '0;
        wrap_nxt = ~wrap;
      end else begin
        idx_nxt  = idx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (adv) begin
      idx  <= idx_nxt;
      wrap <= wrap_nxt;
    end
  end
endmodule

// File: rtl/rxq_get_trk.sv
module rxq_get_trk #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] new_idx,
  output logic [IDX_W-1:0] idx,
  output logic             wrap,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             wrap_nxt
);
  always_comb begin
    idx_nxt  = idx;
    wrap_nxt = wrap;
    if (load) begin
      idx_nxt  = new_idx;
      wrap_nxt = (new_idx < idx) ? ~wrap : wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (load) begin
      idx  <= idx_nxt;
      wrap <= wrap_nxt;
    end
  end
endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;
  logic upd;

  always_comb begin
    upd   = set | clr;
    q_nxt = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 16,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic [CNT_W-1:0]  cfg_wmark,
  input  logic              store_req,
  input  logic              store_done,
  output logic              store_grant,
  output logic              store_drop,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_get_idx,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [CNT_W-1:0]  fill_level,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              flag_full,
  output logic              flag_wmark,
  output logic              flag_lost,
  input  logic              clr_wmark,
  input  logic              clr_lost
);
  import rxq_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  store_st_e        st_q, st_d;
  logic             busy, commit, ack_load;
  logic             put_wrap, get_wrap, put_wrap_nxt, get_wrap_nxt;
  logic [IDX_W-1:0] put_nxt, get_nxt;
  logic [CNT_W-1:0] fill_nxt;
  logic             wm_set;

  function automatic logic [CNT_W-1:0] level_of(
    input logic [IDX_W-1:0] p, input logic pw,
    input logic [IDX_W-1:0] g, input logic gw,
    input logic [CNT_W-1:0] sz);
    if (pw == gw) level_of = {1'b0, p} - {1'b0, g};
    else          level_of = sz - ({1'b0, g} - {1'b0, p});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb begin
    busy        = (st_q == ST_BUSY);
    store_grant = store_req & ~busy & ~flag_full;
    store_drop  = store_req & ~busy & flag_full;
    commit      = busy & store_done;
    ack_load    = ack_valid & (ack_get_idx != get_idx);
    st_d        = st_q;
    if (store_grant)  st_d = ST_BUSY;
    else if (commit)  st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  rxq_put_ctr #(.IDX_W(IDX_W)) u_put (
    .clk(clk), .rst_n(rst_n_i), .adv(commit), .cfg_size(cfg_size),
    .idx(put_idx), .wrap(put_wrap), .idx_nxt(put_nxt), .wrap_nxt(put_wrap_nxt)
  );

  rxq_get_trk #(.IDX_W(IDX_W)) u_get (
    .clk(clk), .rst_n(rst_n_i), .load(ack_load), .new_idx(ack_get_idx),
    .idx(get_idx), .wrap(get_wrap), .idx_nxt(get_nxt), .wrap_nxt(get_wrap_nxt)
  );

  always_comb begin
    fill_level = level_of(put_idx, put_wrap, get_idx, get_wrap, cfg_size);
    fill_nxt   = level_of(put_nxt, put_wrap_nxt, get_nxt, get_wrap_nxt, cfg_size);
    flag_full  = (fill_level == cfg_size);
    wm_set     = commit & (cfg_wmark != '0) & (fill_nxt == cfg_wmark);
    wr_addr    = cfg_start_addr + ADDR_W'({put_idx, 2'b00});
    rd_addr    = cfg_start_addr + ADDR_W'({get_idx, 2'b00});
  end

  rxq_sticky u_wm_flag (
    .clk(clk), .rst_n(rst_n_i), .set(wm_set), .clr(clr_wmark), .q(flag_wmark)
  );

  rxq_sticky u_lost_flag (
    .clk(clk), .rst_n(rst_n_i), .set(store_drop), .clr(clr_lost), .q(flag_lost)
  );
endmodule

// File: rtl/rxq_index_mgr_chk.sv
module rxq_index_mgr_chk #(
  parameter int IDX_W = 6,
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             store_req,
  input logic             store_done,
  input logic             store_grant,
  input logic             store_drop,
  input logic             flag_full,
  input logic             flag_wmark,
  input logic             flag_lost,
  input logic             clr_lost,
  input logic [CNT_W-1:0] cfg_wmark,
  input logic [CNT_W-1:0] cfg_size,
  input logic [IDX_W-1:0] put_idx,
  input logic [CNT_W-1:0] fill_level
);
  assert_grant_drop_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_grant && store_drop));

  assert_put_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !store_done |=> $stable(put_idx));

  assert_full_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> !store_grant);

  assert_drop_sets_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_drop |=> flag_lost);

  assert_wmark_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wmark == '0 && !flag_wmark) |=> !flag_wmark);

  assert_lost_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_lost && !clr_lost) |=> flag_lost);

  assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= cfg_size);

  assert_drop_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_grant || store_drop) |-> store_req);
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .store_req(store_req), .store_done(store_done),
  .store_grant(store_grant), .store_drop(store_drop), .flag_full(flag_full),
  .flag_wmark(flag_wmark), .flag_lost(flag_lost), .clr_lost(clr_lost),
  .cfg_wmark(cfg_wmark), .cfg_size(cfg_size), .put_idx(put_idx),
  .fill_level(fill_level)
);

// File: tb/rxq_index_mgr_bench.sv
module rxq_index_mgr_bench;
  localparam int CLK_P  = 10;
  localparam int IDX_W  = 6;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = IDX_W + 1;
  localparam int NROW   = 22;

  // row: req done ack idx[6] clrw clrl | grant drop put[6] get[6] fill[7] full wm lost
  localparam logic [34:0] TBL [NROW] = '{
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd0, 6'd0, 7'd0, 3'b000},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd1, 6'd0, 7'd1, 3'b000},
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd1, 6'd0, 7'd1, 3'b000},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd2, 6'd0, 7'd2, 3'b000},
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd2, 6'd0, 7'd2, 3'b000},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd3, 6'd0, 7'd3, 3'b010},
    {3'b000, 6'd0, 2'b10, 2'b00, 6'd3, 6'd0, 7'd3, 3'b000},
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd3, 6'd0, 7'd3, 3'b000},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd0, 6'd0, 7'd4, 3'b100},
    {3'b100, 6'd0, 2'b00, 2'b01, 6'd0, 6'd0, 7'd4, 3'b101},
    {3'b001, 6'd1, 2'b00, 2'b00, 6'd0, 6'd1, 7'd3, 3'b001},
    {3'b100, 6'd0, 2'b01, 2'b10, 6'd0, 6'd1, 7'd3, 3'b000},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd1, 6'd1, 7'd4, 3'b100},
    {3'b100, 6'd0, 2'b01, 2'b01, 6'd1, 6'd1, 7'd4, 3'b101},
    {3'b001, 6'd3, 2'b00, 2'b00, 6'd1, 6'd3, 7'd2, 3'b001},
    {3'b001, 6'd1, 2'b00, 2'b00, 6'd1, 6'd1, 7'd0, 3'b001},
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd1, 6'd1, 7'd0, 3'b001},
    {3'b100, 6'd0, 2'b00, 2'b00, 6'd1, 6'd1, 7'd0, 3'b001},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd2, 6'd1, 7'd1, 3'b001},
    {3'b010, 6'd0, 2'b00, 2'b00, 6'd2, 6'd1, 7'd1, 3'b001},
    {3'b100, 6'd0, 2'b00, 2'b10, 6'd2, 6'd1, 7'd1, 3'b001},
    {3'b011, 6'd2, 2'b00, 2'b00, 6'd3, 6'd2, 7'd1, 3'b001}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] cfg_start_addr;
  logic [CNT_W-1:0]  cfg_size, cfg_wmark;
  logic              store_req, store_done, store_grant, store_drop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              ack_valid;
  logic [IDX_W-1:0]  ack_get_idx, put_idx, get_idx;
  logic [CNT_W-1:0]  fill_level;
  logic              flag_full, flag_wmark, flag_lost, clr_wmark, clr_lost;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rxq_index_mgr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_rxq_index_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr), .cfg_size(cfg_size),
    .cfg_wmark(cfg_wmark), .store_req(store_req), .store_done(store_done),
    .store_grant(store_grant), .store_drop(store_drop), .wr_addr(wr_addr),
    .ack_valid(ack_valid), .ack_get_idx(ack_get_idx), .put_idx(put_idx),
    .get_idx(get_idx), .fill_level(fill_level), .rd_addr(rd_addr),
    .flag_full(flag_full), .flag_wmark(flag_wmark), .flag_lost(flag_lost),
    .clr_wmark(clr_wmark), .clr_lost(clr_lost)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    store_req = 1'b0; store_done = 1'b0; ack_valid = 1'b0;
    ack_get_idx = '0; clr_wmark = 1'b0; clr_lost = 1'b0;
  endtask

  task automatic do_reset(input int size, input int wm);
    rst_n = 1'b0;
    idle_inputs();
    cfg_start_addr = 16'h0100;
    cfg_size  = CNT_W'(size);
    cfg_wmark = CNT_W'(wm);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one cycle: inputs at negedge, combinational outputs checked before the edge
  task automatic step(input logic rq, input logic dn, input logic av, input int ai,
                      input logic cw, input logic cl);
    @(negedge clk);
    store_req = rq; store_done = dn; ack_valid = av;
    ack_get_idx = IDX_W'(ai); clr_wmark = cw; clr_lost = cl;
    #1;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    rst_n = 1'b0;
    idle_inputs();
    cfg_start_addr = 16'h0100; cfg_size = 7'd4; cfg_wmark = 7'd3;
    #(CLK_P * 2 + 1);
    chk("R9 put in reset", int'(put_idx), 0);
    chk("R9 flags in reset", int'({flag_full, flag_wmark, flag_lost}), 0);
    do_reset(4, 3);
    chk("R9 fill after reset", int'(fill_level), 0);
    chk("R9 get after reset", int'(get_idx), 0);
    chk("R7 rd_addr after reset", int'(rd_addr), 'h100);

    // table walk: depth 4, watermark 3
    for (int r = 0; r < NROW; r++) begin
      logic [34:0] v;
      v = TBL[r];
      step(v[34], v[33], v[32], int'(v[31:26]), v[25], v[24]);
      chk($sformatf("R1/R10 grant row %0d", r), int'(store_grant), int'(v[23]));
      chk($sformatf("R3/R10 drop row %0d", r), int'(store_drop), int'(v[22]));
      if (v[23])
        chk($sformatf("R1 wr_addr row %0d", r), int'(wr_addr), 'h100 + 4 * int'(v[21:16]));
      settle();
      chk($sformatf("R2 put row %0d", r), int'(put_idx), int'(v[21:16]));
      chk($sformatf("R6 get row %0d", r), int'(get_idx), int'(v[15:10]));
      chk($sformatf("R6 fill row %0d", r), int'(fill_level), int'(v[9:3]));
      chk($sformatf("R3 full row %0d", r), int'(flag_full), int'(v[2]));
      chk($sformatf("R5/R8 wmark row %0d", r), int'(flag_wmark), int'(v[1]));
      chk($sformatf("R4/R8 lost row %0d", r), int'(flag_lost), int'(v[0]));
      chk($sformatf("R7 rd_addr row %0d", r), int'(rd_addr), 'h100 + 4 * int'(v[15:10]));
    end

    // R11: depth 1
    do_reset(1, 1);
    step(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    chk("R11 depth1 grant", int'(store_grant), 1);
    settle();
    step(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    settle();
    chk("R11 depth1 put wraps", int'(put_idx), 0);
    chk("R11 depth1 full", int'(flag_full), 1);
    chk("R5 depth1 wmark", int'(flag_wmark), 1);
    step(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    chk("R3 depth1 drop", int'(store_drop), 1);
    settle();

    // R11/R5: depth 64, watermark disabled
    do_reset(64, 0);
    for (int k = 0; k < 64; k++) begin
      step(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      if (k == 63) begin
        chk("R11 depth64 last grant", int'(store_grant), 1);
        chk("R1 depth64 last wr_addr", int'(wr_addr), 'h100 + 252);
      end
      settle();
      step(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      settle();
    end
    chk("R11 depth64 fill", int'(fill_level), 64);
    chk("R11 depth64 put wraps", int'(put_idx), 0);
    chk("R3 depth64 full", int'(flag_full), 1);
    chk("R5 wmark disabled at 0", int'(flag_wmark), 0);
    step(1'b0, 1'b0, 1'b1, 32, 1'b0, 1'b0);
    settle();
    chk("R6 depth64 fill after ack", int'(fill_level), 32);
    chk("R7 depth64 rd_addr", int'(rd_addr), 'h100 + 128);

    // R8: set and clear of the watermark in the same cycle
    do_reset(4, 1);
    step(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    settle();
    step(1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0);
    settle();
    chk("R8 wmark set beats clear", int'(flag_wmark), 1);
    step(1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0);
    settle();
    chk("R8 wmark cleared", int'(flag_wmark), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule